// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache Controller

This block is a read-only, direct-mapped instruction cache placed between a CPU fetch port and a wide backing-memory port. Each line holds 256 bits, which is eight 32-bit instructions, and a fill brings the whole line in one transfer. A hit is answered in the same cycle as the request. A miss asks the memory for the line-aligned address, waits for the data and returns the requested word in the cycle the data arrives.

A 3-bit mode input sets the policy. In the normal mode a miss allocates the line. In freeze, hits are served but a miss leaves the arrays unchanged. In bypass every access goes to memory. Changing the mode never touches the tag or valid state.

Software keeps the cache coherent after changing program memory through two registers. One holds a start address. The other takes a word count, which launches a sequencer that clears one line per cycle. Fetches stall while the sequencer runs.

The controller is built around three named states. **IDLE** looks up the tags. **FILL** holds the memory request. **INVAL** steps the sequencer. The transitions are:
- **IDLE→INVAL**: a count is pending. This takes priority over a fetch.
- **IDLE→FILL**: a fetch misses and no count is pending.
- **FILL→IDLE**: the memory returns its data.
- **INVAL→IDLE**: the step that covers the last requested word.

Top module: `icache_ctrl`

## Requirements
- R1: After reset every line is invalid, `f_ready` and `m_req` are low, and both registers read 0.
- R2: A miss in mode 010 raises `m_req` with `m_addr` equal to the fetch address with bits [4:0] cleared. `m_req` and `m_addr` hold until `m_valid`. In that cycle `f_ready` rises with word `m_data[32*w +: 32]`, where w = `f_addr[4:2]`, and the line is written into the cache.
- R3: A fetch that hits in a mode that reads the cache gets `f_ready` in the cycle it is presented. It gets the stored word and does not raise `m_req`.
- R4: With the defaults, the line index is `f_addr[14:5]` and the tag is `f_addr[31:15]`. A fill into an index replaces the line stored there, so the old address misses afterwards.
- R5: Mode 000 behaves exactly like 010: hits are served and misses allocate.
- R6: Mode 011 (freeze) serves hits. A miss is served from memory but allocates nothing, so a repeated miss goes to memory again.
- R7: Mode 100 (bypass) sends every fetch to memory and allocates nothing. The stored lines survive.
- R8: Codes 001, 101, 110 and 111 behave like bypass: pass-through with no hit and no allocation.
- R9: Changing the mode invalidates nothing. Lines filled earlier hit again when mode 010 returns.
- R10: Byte offset 0x0 is the invalidate start address and reads back as written. Byte offset 0x4 is the word count. Writing a nonzero count while idle starts a sequence. Each step subtracts the number of words from the current position to the end of its line, and 0x4 reads the remaining count until it reaches 0.
- R11: The sequence clears the valid bit of every index touched by the byte range [start, start+4*count), and lines at other indexes still hit. A count written while a sequence is running is ignored.
- R12: While a sequence is pending, no fetch is answered and no memory request starts. A count written during a fill lets that fill finish and then invalidates the line it filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 3 | Cache policy code |
| f_req | input | 1 | Fetch request, held until `f_ready` |
| f_addr | input | 32 | Fetch byte address |
| f_ready | output | 1 | Fetch answered this cycle |
| f_data | output | 32 | Instruction word, valid with `f_ready` |
| m_req | output | 1 | Line read request to memory |
| m_addr | output | 32 | Line-aligned memory address |
| m_valid | input | 1 | Memory line data valid |
| m_data | input | 256 | Memory line data |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |

## Verification
Two of the block's functions can meet in the same window: a line fill and an invalidate request. The bench starts a fetch that misses. One cycle later, while the memory request is still open, it writes a count whose range covers that very line. The check expects three things:
- The fetch completes with the fresh memory word.
- The sequencer runs only after the fill has been written.
- The next fetch to the line misses again, because the line is not left valid with data that predates the invalidate.

// File: rtl/icache_pkg.sv
`timescale 1ns/1ps
package icache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_INVAL = 2'd2
    } ic_state_e;

    localparam logic [2:0] MODE_LEGACY = 3'b000;
    localparam logic [2:0] MODE_ENABLE = 3'b010;
    localparam logic [2:0] MODE_FREEZE = 3'b011;
    localparam logic [2:0] MODE_BYPASS = 3'b100;

    // Hits may be served from the arrays.
    function automatic logic mode_reads_cache(input logic [2:0] m);
        return (m == MODE_LEGACY) || (m == MODE_ENABLE) || (m == MODE_FREEZE);
    endfunction

    // A miss writes the returned line into the arrays.
    function automatic logic mode_allocates(input logic [2:0] m);
        return (m == MODE_LEGACY) || (m == MODE_ENABLE);
    endfunction

endpackage

// File: rtl/icache_store.sv
`timescale 1ns/1ps
module icache_store #(
    parameter int unsigned LINES  = 1024,
    parameter int unsigned TAG_W  = 17,
    parameter int unsigned LINE_W = 256,
    localparam int unsigned IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [LINE_W-1:0] wr_line,
    input  logic              clr_en,
    input  logic [IDX_W-1:0]  clr_idx
);

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_mem  [LINES];
    logic [LINE_W-1:0] line_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (wr_en)  valid_q[wr_idx]  <= 1'b1;
            if (clr_en) valid_q[clr_idx] <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            line_mem[wr_idx] <= wr_line;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_line  = line_mem[rd_idx];

endmodule

// File: rtl/icache_inval.sv
`timescale 1ns/1ps
module icache_inval #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 5,
    parameter int unsigned IDX_W  = 10,
    parameter int unsigned BOFF_W = 2,
    localparam int unsigned WSEL_W     = OFF_W - BOFF_W,
    localparam int unsigned LINE_WORDS = 1 << WSEL_W,
    localparam int unsigned HI_W       = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [3:0]        reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    input  logic              step_en,
    output logic              busy,
    output logic              last,
    output logic [IDX_W-1:0]  clr_idx,
    output logic [ADDR_W-1:0] remaining
);

    logic [ADDR_W-1:0]        start_q;
    logic [ADDR_W-1:0]        cnt_q;
    logic [ADDR_W-BOFF_W-1:0] cur_q;   // word address of the next step
    logic [ADDR_W-1:0]        span;    // words from cur_q to the end of its line

    assign span      = ADDR_W'(LINE_WORDS) - ADDR_W'(cur_q[WSEL_W-1:0]);
    assign busy      = (cnt_q != '0);
    assign last      = busy && (cnt_q <= span);
    assign clr_idx   = cur_q[WSEL_W +: IDX_W];
    assign remaining = cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            cnt_q   <= '0;
            cur_q   <= '0;
        end else begin
            if (reg_wr && (reg_addr == 4'h0)) begin
                start_q <= reg_wdata;
            end
            if (step_en && busy) begin
                cnt_q <= last ? '0 : (cnt_q - span);
                cur_q <= {cur_q[ADDR_W-BOFF_W-1 -: HI_W] + HI_W'(1), {WSEL_W{1'b0}}};
            end else if (reg_wr && (reg_addr == 4'h4) && !busy) begin
                cnt_q <= reg_wdata;
                cur_q <= start_q[ADDR_W-1:BOFF_W];
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            4'h0:    reg_rdata = start_q;
            4'h4:    reg_rdata = cnt_q;
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/icache_ctrl.sv
`timescale 1ns/1ps
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned CACHE_BYTES = 32768,
    parameter int unsigned LINE_BITS   = 256,
    parameter int unsigned WORD_BITS   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           mode_i,
    input  logic                 f_req,
    input  logic [ADDR_W-1:0]    f_addr,
    output logic                 f_ready,
    output logic [WORD_BITS-1:0] f_data,
    output logic                 m_req,
    output logic [ADDR_W-1:0]    m_addr,
    input  logic                 m_valid,
    input  logic [LINE_BITS-1:0] m_data,
    input  logic                 reg_wr,
    input  logic [3:0]           reg_addr,
    input  logic [ADDR_W-1:0]    reg_wdata,
    output logic [ADDR_W-1:0]    reg_rdata
);

    localparam int unsigned LINE_BYTES = LINE_BITS / 8;
    localparam int unsigned WPL        = LINE_BITS / WORD_BITS;
    localparam int unsigned OFF_W      = $clog2(LINE_BYTES);
    localparam int unsigned BOFF_W     = $clog2(WORD_BITS / 8);
    localparam int unsigned WOFF_W     = $clog2(WPL);
    localparam int unsigned LINES      = CACHE_BYTES / LINE_BYTES;
    localparam int unsigned IDX_W      = $clog2(LINES);
    localparam int unsigned TAG_W      = ADDR_W - IDX_W - OFF_W;
    localparam int unsigned HI_W       = ADDR_W - OFF_W;

    // Fetch address fields
    logic [IDX_W-1:0]  f_idx;
    logic [TAG_W-1:0]  f_tag;
    logic [WOFF_W-1:0] f_woff;
    logic              addr_lsb_unused;

    assign f_idx           = f_addr[OFF_W +: IDX_W];
    assign f_tag           = f_addr[ADDR_W-1 -: TAG_W];
    assign f_woff          = f_addr[BOFF_W +: WOFF_W];
    assign addr_lsb_unused = ^f_addr[BOFF_W-1:0];

    // Arrays
    logic                 rd_valid;
    logic [TAG_W-1:0]     rd_tag;
    logic [LINE_BITS-1:0] rd_line;
    logic                 fill_we;

    // Fill context captured at the miss
    logic [HI_W-1:0]   fill_line_q;
    logic [WOFF_W-1:0] fill_woff_q;
    logic              fill_alloc_q;

    // Invalidate sequencer
    logic              inv_busy;
    logic              inv_last;
    logic              inv_step;
    logic [IDX_W-1:0]  inv_idx;
    logic [ADDR_W-1:0] inv_cnt;

    icache_store #(
        .LINES  (LINES),
        .TAG_W  (TAG_W),
        .LINE_W (LINE_BITS)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (f_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_line  (rd_line),
        .wr_en    (fill_we),
        .wr_idx   (fill_line_q[IDX_W-1:0]),
        .wr_tag   (fill_line_q[HI_W-1 -: TAG_W]),
        .wr_line  (m_data),
        .clr_en   (inv_step),
        .clr_idx  (inv_idx)
    );

    icache_inval #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .BOFF_W (BOFF_W)
    ) u_inval (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .step_en   (inv_step),
        .busy      (inv_busy),
        .last      (inv_last),
        .clr_idx   (inv_idx),
        .remaining (inv_cnt)
    );

    // Word selection from the stored line and from the memory bus
    logic [WORD_BITS-1:0] cache_words [WPL];
    logic [WORD_BITS-1:0] mem_words   [WPL];

    for (genvar g = 0; g < WPL; g++) begin : g_words
        assign cache_words[g] = rd_line[g*WORD_BITS +: WORD_BITS];
        assign mem_words[g]   = m_data[g*WORD_BITS +: WORD_BITS];
    end

    logic hit;
    logic miss_take;

    assign hit       = mode_reads_cache(mode_i) && rd_valid && (rd_tag == f_tag);
    assign miss_take = (state_q == ST_IDLE) && !inv_busy && f_req && !hit;

    ic_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_line_q  <= '0;
            fill_woff_q  <= '0;
            fill_alloc_q <= 1'b0;
        end else if (miss_take) begin
            fill_line_q  <= f_addr[ADDR_W-1:OFF_W];
            fill_woff_q  <= f_woff;
            fill_alloc_q <= mode_allocates(mode_i);
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (inv_busy)       state_d = ST_INVAL;
                else if (miss_take) state_d = ST_FILL;
            end
            ST_FILL:  if (m_valid)  state_d = ST_IDLE;
            ST_INVAL: if (inv_last) state_d = ST_IDLE;
            default:                state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        f_ready  = 1'b0;
        f_data   = cache_words[f_woff];
        m_req    = 1'b0;
        fill_we  = 1'b0;
        inv_step = 1'b0;
        unique case (state_q)
            ST_IDLE: f_ready = f_req && !inv_busy && hit;
            ST_FILL: begin
                m_req   = 1'b1;
                f_ready = m_valid;
                f_data  = mem_words[fill_woff_q];
                fill_we = m_valid && fill_alloc_q;
            end
            ST_INVAL: inv_step = 1'b1;
            default: ;
        endcase
    end

    assign m_addr = {fill_line_q, {OFF_W{1'b0}}};

endmodule

// File: rtl/icache_ctrl_chk.sv
`timescale 1ns/1ps
module icache_ctrl_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              f_req,
    input logic              f_ready,
    input logic [2:0]        mode_i,
    input logic              m_req,
    input logic              m_valid,
    input logic [ADDR_W-1:0] m_addr,
    input logic              inv_step,
    input logic [ADDR_W-1:0] inv_cnt
);

    a_r2_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_valid) |=> m_req)
        else $error("R2: memory request dropped before data");

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_valid) |=> $stable(m_addr))
        else $error("R2: memory address moved during a fill");

    a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        f_ready |-> f_req)
        else $error("R3: answer without a request");

    a_r7_bypass_never_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ready && (mode_i == 3'b100)) |-> m_req)
        else $error("R7: bypass fetch answered from the arrays");

    a_r10_count_drops: assert property (@(posedge clk) disable iff (!rst_n)
        inv_step |=> (inv_cnt < $past(inv_cnt)))
        else $error("R10: remaining count did not fall");

    a_r12_stall_in_inval: assert property (@(posedge clk) disable iff (!rst_n)
        inv_step |-> (!f_ready && !m_req))
        else $error("R12: fetch activity during invalidation");

endmodule

bind icache_ctrl icache_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .f_req    (f_req),
    .f_ready  (f_ready),
    .mode_i   (mode_i),
    .m_req    (m_req),
    .m_valid  (m_valid),
    .m_addr   (m_addr),
    .inv_step (inv_step),
    .inv_cnt  (inv_cnt)
);

// File: tb/tb_icache_ctrl.sv
`timescale 1ns/1ps
module tb_icache_ctrl;

    localparam int MEM_LAT = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode_i = 3'b010;
    logic         f_req = 1'b0;
    logic [31:0]  f_addr = '0;
    logic         f_ready;
    logic [31:0]  f_data;
    logic         m_req;
    logic [31:0]  m_addr;
    logic         m_valid = 1'b0;
    logic [255:0] m_data = '0;
    logic         reg_wr = 1'b0;
    logic [3:0]   reg_addr = '0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;

    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;
    logic [7:0] mem_gen = 8'd0;
    int   mem_cnt = 0;

    logic [31:0] exp_data_q[$];
    bit          exp_miss_q[$];
    string       exp_req_q[$];

    icache_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .f_req     (f_req),
        .f_addr    (f_addr),
        .f_ready   (f_ready),
        .f_data    (f_data),
        .m_req     (m_req),
        .m_addr    (m_addr),
        .m_valid   (m_valid),
        .m_data    (m_data),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    always #2.5 clk = ~clk;

    function automatic logic [31:0] word_of(input logic [31:0] a, input logic [7:0] g);
        return {g, a[23:2], 2'b00};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Backing memory: answers a held request after MEM_LAT cycles
    always @(posedge clk) begin
        if (!rst_n) begin
            m_valid <= 1'b0;
            mem_cnt <= 0;
        end else if (m_req && !m_valid) begin
            if (mem_cnt == MEM_LAT - 1) begin
                m_valid <= 1'b1;
                mem_cnt <= 0;
                for (int w = 0; w < 8; w++)
                    m_data[w*32 +: 32] <= word_of(m_addr + 32'(w * 4), mem_gen);
            end else begin
                mem_cnt <= mem_cnt + 1;
            end
        end else begin
            m_valid <= 1'b0;
        end
    end

    // Monitor: compares every answered fetch against the scoreboard
    always @(negedge clk) begin
        #1;
        if (rst_n && f_ready) begin
            if (exp_data_q.size() == 0) begin
                chk(1'b0, "R3 unexpected answer", f_data, 32'h0);
            end else begin
                logic [31:0] ed;
                bit          em;
                string       rq;
                ed = exp_data_q.pop_front();
                em = exp_miss_q.pop_front();
                rq = exp_req_q.pop_front();
                chk(f_data == ed, {rq, " data"}, f_data, ed);
                chk(m_req == em, {rq, " hit/miss"}, 32'(m_req), 32'(em));
            end
        end
    end

    // Driver: starts and ends at a negative edge
    task automatic fetch(input logic [31:0] a, input bit miss, input logic [7:0] g,
                         input string req, output int lat);
        exp_data_q.push_back(word_of(a, g));
        exp_miss_q.push_back(miss);
        exp_req_q.push_back(req);
        f_addr = a;
        f_req  = 1'b1;
        lat    = 0;
        #1;
        while (!f_ready) begin
            @(negedge clk);
            #1;
            lat++;
        end
        @(negedge clk);
        f_req = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    localparam logic [31:0] LA = 32'h0000_1000;  // index 0x080
    localparam logic [31:0] LB = 32'h0000_1040;  // index 0x082
    localparam logic [31:0] LC = 32'h0000_9000;  // index 0x080, other tag
    localparam logic [31:0] LD = 32'h0000_2000;  // index 0x100
    localparam logic [31:0] LE = 32'h0000_3000;  // index 0x180

    initial begin
        int          lat;
        logic [31:0] v;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        #1;
        chk(f_ready == 1'b0, "R1 f_ready", 32'(f_ready), 32'h0);
        chk(m_req == 1'b0, "R1 m_req", 32'(m_req), 32'h0);
        rd(4'h4, v); chk(v == 0, "R1 count reg", v, 0);
        rd(4'h0, v); chk(v == 0, "R1 start reg", v, 0);
        @(negedge clk);

        // R2 / R1: first fetch misses, fill latency
        mode_i = 3'b010;
        fetch(LA + 8, 1, 8'd0, "R1", lat);
        chk(lat == 3, "R2 miss latency", 32'(lat), 32'd3);

        // R3: hit served from the arrays in the request cycle
        mem_gen = 8'd1;
        fetch(LA + 32'h1c, 0, 8'd0, "R3", lat);
        chk(lat == 0, "R3 hit latency", 32'(lat), 32'd0);

        // R4: conflicting tag replaces the line
        fetch(LC + 4, 1, 8'd1, "R4", lat);
        fetch(LA, 1, 8'd1, "R4", lat);
        fetch(LA + 4, 0, 8'd1, "R4", lat);

        // R5: legacy code allocates
        mode_i = 3'b000;
        fetch(LB, 1, 8'd1, "R5", lat);
        fetch(LB + 8, 0, 8'd1, "R5", lat);

        // R6: freeze
        mem_gen = 8'd2;
        mode_i = 3'b011;
        fetch(LA, 0, 8'd1, "R6", lat);
        fetch(LD, 1, 8'd2, "R6", lat);
        fetch(LD, 1, 8'd2, "R6", lat);

        // R7: bypass
        mode_i = 3'b100;
        fetch(LA, 1, 8'd2, "R7", lat);
        fetch(LA, 1, 8'd2, "R7", lat);

        // R8: reserved codes
        mode_i = 3'b111;
        fetch(LB, 1, 8'd2, "R8", lat);
        mode_i = 3'b101;
        fetch(LB + 4, 1, 8'd2, "R8", lat);

        // R9: earlier lines still present after mode changes
        mode_i = 3'b010;
        fetch(LA, 0, 8'd1, "R9", lat);
        fetch(LB, 0, 8'd1, "R9", lat);
        fetch(LD, 1, 8'd2, "R2", lat);
        fetch(LD + 32'h10, 0, 8'd2, "R3", lat);

        // R10 / R11: range from LA word 6 over four words
        wr(4'h0, LA + 32'h18);
        rd(4'h0, v); chk(v == LA + 32'h18, "R10 start readback", v, LA + 32'h18);
        wr(4'h4, 32'd4);
        rd(4'h4, v); chk(v == 32'd4, "R10 count loaded", v, 32'd4);
        @(negedge clk);
        @(negedge clk);
        rd(4'h4, v); chk(v == 32'd2, "R10 count after partial line", v, 32'd2);
        @(negedge clk);
        rd(4'h4, v); chk(v == 32'd0, "R10 count done", v, 32'd0);
        @(negedge clk);
        fetch(LA + 32'h18, 1, 8'd2, "R11", lat);
        fetch(LB, 0, 8'd1, "R11", lat);

        // R12: fetch stalls while a pending step runs
        wr(4'h0, LB);
        wr(4'h4, 32'd1);
        fetch(LD, 0, 8'd2, "R12", lat);
        chk(lat == 2, "R12 stall length", 32'(lat), 32'd2);
        fetch(LB, 1, 8'd2, "R11", lat);

        // R11: count write while busy is ignored
        wr(4'h0, LD);
        wr(4'h4, 32'd40);
        wr(4'h4, 32'd1);
        rd(4'h4, v); chk(v == 32'd40, "R11 busy write ignored", v, 32'd40);
        @(negedge clk);
        rd(4'h4, v); chk(v == 32'd32, "R10 full line step", v, 32'd32);
        for (int i = 0; i < 20; i++) begin
            rd(4'h4, v);
            if (v == 0) break;
            @(negedge clk);
        end
        chk(v == 32'd0, "R10 count drains", v, 32'd0);
        @(negedge clk);
        fetch(LD, 1, 8'd2, "R11", lat);

        // R12: invalidate written during a fill of the same line
        mem_gen = 8'd3;
        wr(4'h0, LE);
        fork
            fetch(LE, 1, 8'd3, "R12", lat);
            begin
                @(negedge clk);
                wr(4'h4, 32'd8);
            end
        join
        fetch(LE + 4, 1, 8'd3, "R12", lat);
        fetch(LE + 8, 0, 8'd3, "R12", lat);

        repeat (3) @(negedge clk);
        chk(exp_data_q.size() == 0, "R3 all fetches answered", 32'(exp_data_q.size()), 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule